// File: doc/BRIEF.md
# USB Host Interrupt Status Unit

This block keeps the interrupt status of a small USB host controller and presents it as one 8-bit register. Two transfer channels (A and B) and a periodic frame timer each deliver a one-cycle done pulse, and the block latches each one into its own bit. The decoded bus line state (SE0 or IDLE) and the D+ level pass through a two-flop synchronizer. Any change of the synchronized line state is latched as an insert/remove event.

Bit 6 has two meanings, selected by an external mode input. With the mode set, bit 6 is a latched resume-detect flag. With the mode clear, bit 6 is a live presence indicator. Bit 7 always shows the synchronized D+ level, which software uses to tell low-speed from full-speed devices.

Software clears latched bits by writing ones to them. A read strobe loads the current register view into the read-data output. The interrupt request is the OR of the latched sources, each gated by its own enable bit.

Top module: `usb_irq_status`

## Requirements
- R1: After reset all latched flags are 0 and `irq` is 0. With `lineSe0`=1, `dPlus`=0 and `resumeMode`=0, the first read returns 8'h40.
- R2: A pulse on `evtChanA` sets bit 0 and a pulse on `evtChanB` sets bit 1. Each bit stays set until it is cleared.
- R3: A pulse on `evtFrame` sets bit 4, and the bit stays set until it is cleared.
- R4: A write with a 1 in bit 0, 1, 4, 5 or 6 clears that latched flag. A 0 in a bit position leaves that flag unchanged.
- R5: If a set pulse and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R6: Bit 5 is set on any change of the synchronized line state, in either direction (1 to 0 or 0 to 1). The input passes through two flops before the change is detected.
- R7: When `resumeMode`=1, bit 6 reads the latched resume flag. That flag is set by an `evtResume` pulse and is cleared by writing 1 to bit 6.
- R8: When `resumeMode`=0, bit 6 reads the synchronized `lineSe0` level: 1 means no device is attached and 0 means a device is present. An `evtResume` pulse has no effect in this mode.
- R9: Bit 7 reads the synchronized `dPlus` level. Writes never change it.
- R10: Bits 3 and 2 always read 0, and writes to them have no effect.
- R11: `irq` is 1 exactly when a latched flag at bit 0, 1, 4 or 5 has its `irqMask` bit set. The latched bit 6 flag also counts, but only while `resumeMode`=1.
- R12: `rdData` takes the register view on the clock edge at which `rdEn` is 1. It holds its value on all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineSe0 | input | 1 | Decoded line state: 1 = SE0, 0 = IDLE |
| dPlus | input | 1 | D+ line level |
| evtChanA | input | 1 | Channel A done pulse |
| evtChanB | input | 1 | Channel B done pulse |
| evtFrame | input | 1 | Frame timer expiry pulse |
| evtResume | input | 1 | Resume detected pulse |
| resumeMode | input | 1 | 1 = bit 6 is the resume flag, 0 = bit 6 shows presence |
| irqMask | input | 8 | Per-bit interrupt enable |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data; a 1 clears the flag at that position |
| rdEn | input | 1 | Register read strobe |
| rdData | output | 8 | Register view captured at the last read |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the event inputs are single-cycle pulses that are already synchronous to `clk`. They also assume that `rdEn` and `wrEn` are sampled only at clock edges. The stimulus drives every input at the falling edge and holds each event high for exactly one cycle. After a line or D+ change, it waits several cycles before reading, which gives the two-flop synchronizer and the edge detector time to settle. The mode input changes only while no event or write is in flight, so the bit 6 meaning is stable around every check.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int REG_W = 8;

  // Bit positions within the status register
  localparam int BIT_CHAN_A = 0;
  localparam int BIT_CHAN_B = 1;
  localparam int BIT_FRAME  = 4;
  localparam int BIT_LINE   = 5;
  localparam int BIT_DEV    = 6;
  localparam int BIT_DPLUS  = 7;

  // Bits that hold a latched flag
  localparam logic [REG_W-1:0] LATCH_MASK = 8'b0111_0011;
  // Interrupt sources in each mode of bit 6
  localparam logic [REG_W-1:0] IRQ_SRC_RESUME   = 8'b0111_0011;
  localparam logic [REG_W-1:0] IRQ_SRC_PRESENCE = 8'b0011_0011;

  typedef struct packed {
    logic             setA;
    logic             setB;
    logic             setFrame;
    logic             setLine;
    logic             setResume;
    logic [REG_W-1:0] clrBits;
    logic             loadRd;
  } irqStrobes_t;
endpackage

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineSe0,
  input  logic             dPlus,
  input  logic             evtChanA,
  input  logic             evtChanB,
  input  logic             evtFrame,
  input  logic             evtResume,
  input  logic             resumeMode,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdEn,
  output irqStrobes_t      strobes,
  output logic             lineSync,
  output logic             dPlusSync
);
  logic [SYNC_STAGES-1:0] lineShift;
  logic [SYNC_STAGES-1:0] dShift;
  logic                   linePrev;

  // Line state resets to SE0 (nothing attached), so a device that is
  // already present when reset ends shows up as an insertion.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineShift <= '1;
      dShift    <= '0;
      linePrev  <= 1'b1;
    end else begin
      lineShift <= {lineShift[SYNC_STAGES-2:0], lineSe0};
      dShift    <= {dShift[SYNC_STAGES-2:0], dPlus};
      linePrev  <= lineShift[SYNC_STAGES-1];
    end
  end

  assign lineSync  = lineShift[SYNC_STAGES-1];
  assign dPlusSync = dShift[SYNC_STAGES-1];

  always_comb begin
    strobes.setA      = evtChanA;
    strobes.setB      = evtChanB;
    strobes.setFrame  = evtFrame;
    strobes.setLine   = lineSync ^ linePrev;
    strobes.setResume = evtResume & resumeMode;
    strobes.clrBits   = wrEn ? (wrData & LATCH_MASK) : '0;
    strobes.loadRd    = rdEn;
  end
endmodule

// File: rtl/usb_irq_dpath.sv
module usb_irq_dpath
  import usb_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobes_t      strobes,
  input  logic             lineSync,
  input  logic             dPlusSync,
  input  logic             resumeMode,
  input  logic [REG_W-1:0] irqMask,
  output logic [REG_W-1:0] statusView,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);
  logic [REG_W-1:0] flags;
  logic [REG_W-1:0] setVec;

  always_comb begin
    setVec             = '0;
    setVec[BIT_CHAN_A] = strobes.setA;
    setVec[BIT_CHAN_B] = strobes.setB;
    setVec[BIT_FRAME]  = strobes.setFrame;
    setVec[BIT_LINE]   = strobes.setLine;
    setVec[BIT_DEV]    = strobes.setResume;
  end

  // A set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= ((flags & ~strobes.clrBits) | setVec) & LATCH_MASK;
  end

  always_comb begin
    statusView            = flags & LATCH_MASK;
    statusView[BIT_DEV]   = resumeMode ? flags[BIT_DEV] : lineSync;
    statusView[BIT_DPLUS] = dPlusSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobes.loadRd) rdData <= statusView;
  end

  assign irq = |(flags & irqMask & (resumeMode ? IRQ_SRC_RESUME : IRQ_SRC_PRESENCE));
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineSe0,
  input  logic             dPlus,
  input  logic             evtChanA,
  input  logic             evtChanB,
  input  logic             evtFrame,
  input  logic             evtResume,
  input  logic             resumeMode,
  input  logic [REG_W-1:0] irqMask,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdEn,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);
  irqStrobes_t      strobes;
  logic             lineSync;
  logic             dPlusSync;
  logic [REG_W-1:0] statusView;

  usb_irq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .lineSe0(lineSe0), .dPlus(dPlus),
    .evtChanA(evtChanA), .evtChanB(evtChanB), .evtFrame(evtFrame),
    .evtResume(evtResume), .resumeMode(resumeMode), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .strobes(strobes),
    .lineSync(lineSync), .dPlusSync(dPlusSync)
  );

  usb_irq_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lineSync(lineSync),
    .dPlusSync(dPlusSync), .resumeMode(resumeMode), .irqMask(irqMask),
    .statusView(statusView), .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk
  import usb_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             clrA,
  input logic             wrEn,
  input logic             evtChanA,
  input logic [REG_W-1:0] irqMask,
  input logic [REG_W-1:0] statusView,
  input logic             rdEn,
  input logic [REG_W-1:0] rdData,
  input logic             irq
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[3:2] == 2'b00); // R10

  AST_CLEAR_A: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && clrA && !evtChanA) |=> !statusView[BIT_CHAN_A]); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evtChanA |=> statusView[BIT_CHAN_A]); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (irqMask == '0) |-> !irq); // R11

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R12

  AST_RD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdData == $past(statusView)); // R12
endmodule

bind usb_irq_status usb_irq_status_chk i_chk (
  .clk(clk), .rstN(rstN), .clrA(wrData[0]), .wrEn(wrEn),
  .evtChanA(evtChanA), .irqMask(irqMask), .statusView(statusView),
  .rdEn(rdEn), .rdData(rdData), .irq(irq)
);

// File: tb/test_usb_irq_status.sv
`timescale 1ns/1ps
module test_usb_irq_status;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineSe0 = 1'b1, dPlus = 1'b0;
  logic       evtChanA = 1'b0, evtChanB = 1'b0, evtFrame = 1'b0, evtResume = 1'b0;
  logic       resumeMode = 1'b0;
  logic [7:0] irqMask = 8'h00;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_irq_status i_usb_irq_status (
    .clk(clk), .rstN(rstN), .lineSe0(lineSe0), .dPlus(dPlus),
    .evtChanA(evtChanA), .evtChanB(evtChanB), .evtFrame(evtFrame),
    .evtResume(evtResume), .resumeMode(resumeMode), .irqMask(irqMask),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic a, input logic b, input logic f, input logic r);
    @(negedge clk);
    evtChanA = a; evtChanB = b; evtFrame = f; evtResume = r;
    @(negedge clk);
    evtChanA = 0; evtChanB = 0; evtFrame = 0; evtResume = 0;
  endtask

  task automatic writeReg(input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0; wrData = 0;
  endtask

  task automatic readReg(output logic [7:0] v);
    @(negedge clk); rdEn = 1;
    @(negedge clk); rdEn = 0; v = rdData;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, exp;
    idle(3);
    rstN = 1;
    idle(4);
    check("R1 irq after reset", {7'b0, irq}, 8'h00);
    readReg(v);
    check("R1 reset view", v, 8'h40);

    // R2/R3/R4 sweep: every event pattern against every clear pattern
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < 8; c++) begin
        writeReg(8'hFF);
        pulse(m[0], m[1], m[2], 1'b0);
        writeReg({3'b000, c[2], 2'b00, c[1], c[0]});
        readReg(v);
        exp = {1'b0, 1'b1, 1'b0, m[2] & ~c[2], 2'b00, m[1] & ~c[1], m[0] & ~c[0]};
        check($sformatf("R2/R3/R4 m=%0d c=%0d", m, c), v, exp);
      end
    end

    // R5: set and clear of the same bit in one cycle
    writeReg(8'hFF);
    @(negedge clk); evtChanA = 1; evtChanB = 1; wrEn = 1; wrData = 8'h03;
    @(negedge clk); evtChanA = 0; evtChanB = 0; wrEn = 0; wrData = 0;
    readReg(v);
    check("R5 set wins", v, 8'h43);

    // R10: reserved bits
    writeReg(8'hFF);
    writeReg(8'h0C);
    readReg(v);
    check("R10 reserved zero", v & 8'h0C, 8'h00);

    // R6/R8: insertion, then removal
    writeReg(8'hFF);
    @(negedge clk); lineSe0 = 0;
    idle(5);
    readReg(v);
    check("R6 insert sets bit5", v & 8'h20, 8'h20);
    check("R8 present reads 0", v & 8'h40, 8'h00);
    writeReg(8'h20);
    readReg(v);
    check("R4 clear bit5", v & 8'h20, 8'h00);
    @(negedge clk); lineSe0 = 1;
    idle(5);
    readReg(v);
    check("R6 removal sets bit5", v & 8'h20, 8'h20);
    check("R8 absent reads 1", v & 8'h40, 8'h40);

    // R8: resume pulse ignored in presence mode
    writeReg(8'hFF);
    @(negedge clk); lineSe0 = 0;
    idle(5);
    writeReg(8'hFF);
    pulse(0, 0, 0, 1);
    readReg(v);
    check("R8 resume ignored", v, 8'h00);
    @(negedge clk); resumeMode = 1;
    readReg(v);
    check("R8 no hidden resume flag", v & 8'h40, 8'h00);

    // R7: resume flag
    pulse(0, 0, 0, 1);
    readReg(v);
    check("R7 resume latched", v & 8'h40, 8'h40);
    writeReg(8'h40);
    readReg(v);
    check("R7 resume cleared", v & 8'h40, 8'h00);

    // R9: live D+
    @(negedge clk); dPlus = 1;
    idle(4);
    writeReg(8'hFF);
    readReg(v);
    check("R9 dplus high after write", v & 8'h80, 8'h80);
    @(negedge clk); dPlus = 0;
    idle(4);
    readReg(v);
    check("R9 dplus low", v & 8'h80, 8'h00);

    // R11: irq over all enable masks, both modes
    writeReg(8'hFF);
    pulse(1, 1, 1, 1);
    @(negedge clk); lineSe0 = 1;
    idle(5);
    for (int k = 0; k < 256; k++) begin
      @(negedge clk); irqMask = k[7:0];
      #1;
      check($sformatf("R11 resume mode mask=%0d", k), {7'b0, irq}, {7'b0, |(k[7:0] & 8'h73)});
    end
    @(negedge clk); resumeMode = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk); irqMask = k[7:0];
      #1;
      check($sformatf("R11 presence mode mask=%0d", k), {7'b0, irq}, {7'b0, |(k[7:0] & 8'h33)});
    end

    // R12: rdData holds without rdEn
    @(negedge clk); irqMask = 0;
    readReg(v);
    writeReg(8'hFF);
    idle(2);
    check("R12 rdData holds", rdData, v);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule